// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes one or two DDR2 devices from power-on to the point where normal traffic and refresh may begin. After reset it keeps clock-enable low and deselects every device while supply and clock settle. It counts a power-up interval in clock cycles derived from the clock frequency. It then waits for the lock indication of the physical-layer delay loop. Only after both conditions are met does it raise clock-enable and issue the device command sequence.

The sequence per device is: a NOP with clock-enable high, a precharge-all, writes of extended mode registers 2 and 3, an extended-mode write that turns the device DLL on, and a mode write that resets that DLL. A second precharge-all and two auto-refreshes follow. Then comes a mode write with the DLL reset cleared, a long settling wait, and two extended-mode writes: one selects the default output-driver calibration and one leaves calibration. When two devices are configured, the whole device sequence runs again on the second chip select. Only after the last device does the block raise its done flag and the refresh-counter enable. Mode-register payloads arrive on input ports. All waits are parameters.

Top module: `ddr2_init_seq`

## Requirements
- R1: Out of reset, cke is 0, every cs_n bit is 1, and init_done and refresh_en are 0. No chip select goes low while cke is 0, and cke stays 0 for at least PWRUP_US microseconds of clock (CLK_MHZ*PWRUP_US cycles) after reset.
- R2: cke stays 0 and no command is issued while dll_locked is 0. cke rises on the first clock edge at which both the power-up wait has elapsed and dll_locked is 1.
- R3: The first command to a device is a NOP (cs_n low, ras_n/cas_n/we_n = 111) with cke high. The next command follows no sooner than ceil(CLK_MHZ*NOP_NS/1000) cycles later. Once high, cke never falls.
- R4: Per device, the commands come in this order: NOP, precharge-all, EMRS2 (ba=010), EMRS3 (ba=011), EMRS (ba=001), MRS (ba=000), precharge-all, auto-refresh, auto-refresh, MRS (ba=000), EMRS (ba=001), EMRS (ba=001). Pin codes {ras_n,cas_n,we_n} are 010 for precharge, 000 for a mode write and 001 for refresh.
- R5: Precharge-all drives addr bit 10 high. EMRS2 and EMRS3 carry emr2_val and emr3_val unchanged. The first EMRS carries emr_val with bits 9:7 and bit 0 cleared (DLL on). The first MRS carries mr_val with bit 8 set (DLL reset). The second MRS carries mr_val with bit 8 cleared.
- R6: A command follows precharge-all after at least T_RP cycles, auto-refresh after at least T_RFC cycles, and any mode write after at least T_MRD cycles. Every cycle in between carries a NOP to the same device.
- R7: The second MRS is followed by at least max(T_OCD, T_MRD) cycles before the next EMRS. That EMRS carries the DLL-on payload with bits 9:7 = 111 (calibration default). The last EMRS carries it with bits 9:7 = 000 (calibration exit).
- R8: With NUM_CHIPS = 2, the complete device sequence of R3 to R7 repeats on cs_n[1] after it finishes on cs_n[0]. At most one cs_n bit is low in any cycle.
- R9: refresh_en stays 0 until every configured device has finished. init_done and refresh_en rise together at least T_MRD cycles after the last EMRS. They stay 1 with all devices deselected until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_MHZ |
| rst | input | 1 | Synchronous active-high reset |
| dll_locked | input | 1 | Physical-layer delay loop lock indication |
| mr_val | input | ADDR_W | Mode register operating payload |
| emr_val | input | ADDR_W | Extended mode register payload |
| emr2_val | input | ADDR_W | Extended mode register 2 payload |
| emr3_val | input | ADDR_W | Extended mode register 3 payload |
| cke | output | 1 | Clock enable to the devices |
| cs_n | output | NUM_CHIPS | Active-low chip selects |
| ras_n | output | 1 | Row strobe command pin |
| cas_n | output | 1 | Column strobe command pin |
| we_n | output | 1 | Write enable command pin |
| ba | output | BA_W | Bank address, also selects the mode register |
| addr | output | ADDR_W | Address bus, carries mode payloads |
| init_done | output | 1 | Sequence complete, held until reset |
| refresh_en | output | 1 | Enable for the auto-refresh counter |

## Verification
Every output is registered. A command appears on the pins one clock after the edge that launches it. The edge that sees dll_locked high after the power-up wait makes cke visible one cycle later. Each later command, and finally init_done, lands exactly its gap count of cycles after the previous command. The bench samples on the falling edge and stamps each observed command with a free-running cycle count. A monitor pops the expected command from a scoreboard queue and compares opcode, device, bank and payload. It checks the stamped distance to the previous command against the minimum for the pair. The power-up and lock conditions are checked by counting falling edges from reset release to the first cycle with cke high.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_MRS  = 2'd2,
    CMD_REF  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_PWR  = 2'd0,
    ST_LOCK = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } st_e;

  localparam int STEPS_PER_CHIP = 12;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] cmd_pins(cmd_e c);
    case (c)
      CMD_PALL: cmd_pins = 3'b010;
      CMD_MRS:  cmd_pins = 3'b000;
      CMD_REF:  cmd_pins = 3'b001;
      default:  cmd_pins = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R6: once run out the counter rests at zero until reloaded
  a_r6_timer_rests: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);

endmodule

// File: rtl/init_step_table.sv
module init_step_table
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int BA_W    = 3,
  parameter int GAP_W   = 16,
  parameter int NOP_CYC = 100,
  parameter int T_RP    = 4,
  parameter int T_RFC   = 32,
  parameter int T_MRD   = 2,
  parameter int OCD_GAP = 200
) (
  input  logic [3:0]        step,
  input  logic [ADDR_W-1:0] mr_val,
  input  logic [ADDR_W-1:0] emr_val,
  input  logic [ADDR_W-1:0] emr2_val,
  input  logic [ADDR_W-1:0] emr3_val,
  output cmd_e              cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [GAP_W-1:0]  gap
);

  localparam logic [ADDR_W-1:0] A10_BIT   = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] DLLRST    = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] OCD_BITS  = ADDR_W'(7) << 7;
  localparam logic [ADDR_W-1:0] DLL_OFF   = ADDR_W'(1);

  logic [ADDR_W-1:0] emr_base;
  assign emr_base = emr_val & ~(OCD_BITS | DLL_OFF);

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    gap  = GAP_W'(1);
    case (step)
      4'd0:  begin cmd = CMD_NOP;  gap = GAP_W'(NOP_CYC); end
      4'd1:  begin cmd = CMD_PALL; addr = A10_BIT; gap = GAP_W'(T_RP); end
      4'd2:  begin cmd = CMD_MRS;  ba = BA_W'(2); addr = emr2_val; gap = GAP_W'(T_MRD); end
      4'd3:  begin cmd = CMD_MRS;  ba = BA_W'(3); addr = emr3_val; gap = GAP_W'(T_MRD); end
      4'd4:  begin cmd = CMD_MRS;  ba = BA_W'(1); addr = emr_base; gap = GAP_W'(T_MRD); end
      4'd5:  begin cmd = CMD_MRS;  ba = BA_W'(0); addr = mr_val | DLLRST; gap = GAP_W'(T_MRD); end
      4'd6:  begin cmd = CMD_PALL; addr = A10_BIT; gap = GAP_W'(T_RP); end
      4'd7:  begin cmd = CMD_REF;  gap = GAP_W'(T_RFC); end
      4'd8:  begin cmd = CMD_REF;  gap = GAP_W'(T_RFC); end
      4'd9:  begin cmd = CMD_MRS;  ba = BA_W'(0); addr = mr_val & ~DLLRST; gap = GAP_W'(OCD_GAP); end
      4'd10: begin cmd = CMD_MRS;  ba = BA_W'(1); addr = emr_base | OCD_BITS; gap = GAP_W'(T_MRD); end
      4'd11: begin cmd = CMD_MRS;  ba = BA_W'(1); addr = emr_base; gap = GAP_W'(T_MRD); end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_MHZ   = 250,
  parameter int PWRUP_US  = 200,
  parameter int NOP_NS    = 400,
  parameter int T_RP      = 4,
  parameter int T_RFC     = 32,
  parameter int T_MRD     = 2,
  parameter int T_OCD     = 200,
  parameter int NUM_CHIPS = 2,
  parameter int ADDR_W    = 14,
  parameter int BA_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dll_locked,
  input  logic [ADDR_W-1:0]    mr_val,
  input  logic [ADDR_W-1:0]    emr_val,
  input  logic [ADDR_W-1:0]    emr2_val,
  input  logic [ADDR_W-1:0]    emr3_val,
  output logic                 cke,
  output logic [NUM_CHIPS-1:0] cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [BA_W-1:0]      ba,
  output logic [ADDR_W-1:0]    addr,
  output logic                 init_done,
  output logic                 refresh_en
);

  localparam int PWR_CYC = CLK_MHZ * PWRUP_US;
  localparam int NOP_CYC = (CLK_MHZ * NOP_NS + 999) / 1000;
  localparam int OCD_GAP = (T_OCD > T_MRD) ? T_OCD : T_MRD;
  localparam int MAX_A   = (PWR_CYC > NOP_CYC) ? PWR_CYC : NOP_CYC;
  localparam int MAX_B   = (T_RFC > OCD_GAP) ? T_RFC : OCD_GAP;
  localparam int MAX_C   = (T_RP > MAX_B) ? T_RP : MAX_B;
  localparam int MAX_GAP = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int TMR_W   = $clog2(MAX_GAP + 1);
  localparam int CHIP_W  = $clog2(NUM_CHIPS + 1);

  st_e               st;
  logic [3:0]        step;
  logic [CHIP_W-1:0] chip;
  logic              expired;
  logic              fire;
  logic              last_chip_done;
  cmd_e              t_cmd;
  logic [BA_W-1:0]   t_ba;
  logic [ADDR_W-1:0] t_addr;
  logic [TMR_W-1:0]  t_gap;
  logic [NUM_CHIPS-1:0] cs_sel;

  init_step_table #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .GAP_W(TMR_W), .NOP_CYC(NOP_CYC),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .OCD_GAP(OCD_GAP)
  ) u_table (
    .step(step), .mr_val(mr_val), .emr_val(emr_val), .emr2_val(emr2_val),
    .emr3_val(emr3_val), .cmd(t_cmd), .ba(t_ba), .addr(t_addr), .gap(t_gap)
  );

  init_wait_timer #(.W(TMR_W), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(fire), .load_val(t_gap - 1'b1),
    .expired(expired)
  );

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_cs
    assign cs_sel[g] = (chip == CHIP_W'(g));
  end

  assign fire = ((st == ST_LOCK) && dll_locked) || ((st == ST_RUN) && expired);
  assign last_chip_done = (chip == CHIP_W'(NUM_CHIPS));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_PWR;
      step       <= '0;
      chip       <= '0;
      cke        <= 1'b0;
      cs_n       <= '1;
      {ras_n, cas_n, we_n} <= 3'b111;
      ba         <= '0;
      addr       <= '0;
      init_done  <= 1'b0;
      refresh_en <= 1'b0;
    end else begin
      case (st)
        ST_PWR: if (expired) st <= ST_LOCK;
        ST_LOCK, ST_RUN: begin
          if (fire && last_chip_done) begin
            st         <= ST_DONE;
            cs_n       <= '1;
            {ras_n, cas_n, we_n} <= 3'b111;
            ba         <= '0;
            addr       <= '0;
            init_done  <= 1'b1;
            refresh_en <= 1'b1;
          end else if (fire) begin
            st   <= ST_RUN;
            cke  <= 1'b1;
            cs_n <= ~cs_sel;
            {ras_n, cas_n, we_n} <= cmd_pins(t_cmd);
            ba   <= t_ba;
            addr <= t_addr;
            if (step == 4'(STEPS_PER_CHIP - 1)) begin
              step <= '0;
              chip <= chip + 1'b1;
            end else begin
              step <= step + 1'b1;
            end
          end else begin
            {ras_n, cas_n, we_n} <= 3'b111;
            ba   <= '0;
            addr <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  // R1: no device is selected while clock-enable is low
  a_r1_deselect_cke_low: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (&cs_n));

  // R2: clock-enable rises only after the lock input was seen high
  a_r2_lock_before_cke: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> $past(dll_locked));

  // R3: clock-enable never falls once raised
  a_r3_cke_holds: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R8: at most one device selected at a time
  a_r8_single_cs: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  // R9: completion is sticky and refresh enable follows it
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (init_done && refresh_en));

  // R9: no device selected after completion
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (&cs_n));

endmodule

// File: tb/ddr2_init_seq_tb.sv
`timescale 1ns/1ps
module ddr2_init_seq_tb;

  localparam int CLK_MHZ  = 250;
  localparam int PWRUP_US = 20;
  localparam int NOP_NS   = 400;
  localparam int T_RP     = 4;
  localparam int T_RFC    = 32;
  localparam int T_MRD    = 2;
  localparam int T_OCD    = 200;
  localparam int NC       = 2;
  localparam int AW       = 14;
  localparam int PWR_CYC  = CLK_MHZ * PWRUP_US;
  localparam int NOP_CYC  = (CLK_MHZ * NOP_NS + 999) / 1000;

  typedef struct {
    int    kind;   // 0 nop, 1 precharge, 2 mode write, 3 refresh
    int    chip;
    int    ba;
    int    addr;
    int    min_gap;
    string tag;
    string gap_tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dll_locked = 1'b0;
  logic [AW-1:0] mr_val = '0, emr_val = '0, emr2_val = '0, emr3_val = '0;
  logic cke, ras_n, cas_n, we_n, init_done, refresh_en;
  logic [NC-1:0] cs_n;
  logic [2:0] ba;
  logic [AW-1:0] addr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit mon_on = 0;
  bit first_cmd = 1;
  bit done_seen = 0;
  bit finished = 0;
  int last_cyc = 0;
  int prev_act = -1;
  int pend_gap = 0;
  string pend_tag = "R3";
  exp_t sbq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .NOP_NS(NOP_NS), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_OCD(T_OCD), .NUM_CHIPS(NC), .ADDR_W(AW), .BA_W(3)
  ) u_dut (
    .clk(clk), .rst(rst), .dll_locked(dll_locked), .mr_val(mr_val), .emr_val(emr_val),
    .emr2_val(emr2_val), .emr3_val(emr3_val), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done),
    .refresh_en(refresh_en)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(int kind, int chip, int b, int a, string tag, int gap_after, string gtag);
    exp_t e;
    e.kind = kind; e.chip = chip; e.ba = b; e.addr = a; e.tag = tag;
    e.min_gap = pend_gap; e.gap_tag = pend_tag;
    sbq.push_back(e);
    pend_gap = gap_after;
    pend_tag = gtag;
  endtask

  // Expected per-device sequence derived from R3..R7
  task automatic push_chip(int c, int mr, int emr, int e2, int e3);
    int base;
    base = emr & ~32'h381;
    push(0, c, 0, 0, "R3", NOP_CYC, "R3");
    push(1, c, 0, 32'h400, "R4", T_RP, "R6");
    push(2, c, 2, e2, "R5", T_MRD, "R6");
    push(2, c, 3, e3, "R5", T_MRD, "R6");
    push(2, c, 1, base, "R5", T_MRD, "R6");
    push(2, c, 0, mr | 32'h100, "R5", T_MRD, "R6");
    push(1, c, 0, 32'h400, "R4", T_RP, "R6");
    push(3, c, 0, 0, "R4", T_RFC, "R6");
    push(3, c, 0, 0, "R4", T_RFC, "R6");
    push(2, c, 0, mr & ~32'h100, "R5", (T_OCD > T_MRD) ? T_OCD : T_MRD, "R7");
    push(2, c, 1, base | 32'h380, "R7", T_MRD, "R6");
    push(2, c, 1, base, "R7", T_MRD, "R6");
  endtask

  // Monitor: decode pins at the falling edge and compare with the scoreboard
  always @(negedge clk) begin
    int act;
    int kind;
    bit is_cmd;
    exp_t e;
    if (mon_on) begin
      act = -1;
      for (int i = 0; i < NC; i++) if (!cs_n[i]) act = i;
      if (!cke && (cs_n != '1)) chk(0, "R1", "select while cke low", cs_n, '1);
      if (cs_n != '1 && cs_n != ~(NC'(1) << act)) chk(0, "R8", "several selects", cs_n, 0);
      is_cmd = (act >= 0) && (({ras_n, cas_n, we_n} != 3'b111) || (act != prev_act));
      if (is_cmd) begin
        case ({ras_n, cas_n, we_n})
          3'b111: kind = 0;
          3'b010: kind = 1;
          3'b000: kind = 2;
          3'b001: kind = 3;
          default: kind = 9;
        endcase
        if (sbq.size() == 0) begin
          chk(0, "R4", "unexpected command", kind, -1);
        end else begin
          e = sbq.pop_front();
          chk(kind == e.kind, "R4", "command kind", kind, e.kind);
          chk(act == e.chip, "R8", "device", act, e.chip);
          chk(int'(ba) == e.ba, e.tag, "bank", ba, e.ba);
          chk(int'(addr) == e.addr, e.tag, "address", addr, e.addr);
          if (!first_cmd)
            chk((cyc - last_cyc) >= e.min_gap, e.gap_tag, "spacing", cyc - last_cyc, e.min_gap);
          chk(refresh_en == 1'b0, "R9", "refresh before end", refresh_en, 0);
        end
        first_cmd = 0;
        last_cyc = cyc;
      end
      if (init_done && !done_seen) begin
        done_seen = 1;
        chk(sbq.size() == 0, "R9", "commands left at done", sbq.size(), 0);
        chk((cyc - last_cyc) >= T_MRD, "R9", "done spacing", cyc - last_cyc, T_MRD);
        chk(refresh_en == 1'b1, "R9", "refresh with done", refresh_en, 1);
      end
      prev_act = act;
    end
  end

  task automatic run_seq(int mr, int emr, int e2, int e3, bit early_lock);
    int rel;
    int n;
    bit low_ok;
    mon_on = 0;
    rst = 1;
    dll_locked = early_lock;
    mr_val = AW'(mr); emr_val = AW'(emr); emr2_val = AW'(e2); emr3_val = AW'(e3);
    repeat (5) @(negedge clk);
    chk(cke == 0, "R1", "reset cke", cke, 0);
    chk(cs_n == '1, "R1", "reset cs_n", cs_n, '1);
    chk(init_done == 0 && refresh_en == 0, "R1", "reset flags", {init_done, refresh_en}, 0);
    sbq.delete();
    pend_gap = 0; pend_tag = "R3";
    for (int c = 0; c < NC; c++) push_chip(c, mr, emr, e2, e3);
    first_cmd = 1; done_seen = 0; prev_act = -1;
    rst = 0;
    rel = cyc;
    mon_on = 1;
    if (!early_lock) begin
      low_ok = 1;
      while ((cyc - rel) < PWR_CYC + 200) begin
        @(negedge clk);
        if (cke) low_ok = 0;
      end
      chk(low_ok, "R2", "cke low without lock", low_ok, 1);
      dll_locked = 1;
      @(negedge clk);
      chk(cke == 1, "R2", "cke after lock", cke, 1);
    end else begin
      n = 0;
      while (!cke && n < PWR_CYC + 100) begin @(negedge clk); n++; end
      chk(cke == 1, "R2", "cke rises with early lock", cke, 1);
      chk((cyc - rel) >= PWR_CYC, "R1", "power-up wait", cyc - rel, PWR_CYC);
    end
    n = 0;
    while (!init_done && n < 20000) begin @(negedge clk); n++; end
    chk(init_done == 1, "R9", "done reached", init_done, 1);
    low_ok = 1;
    repeat (50) begin
      @(negedge clk);
      if (!(init_done && refresh_en && cke && cs_n == '1)) low_ok = 0;
    end
    chk(low_ok, "R9", "done held and idle", low_ok, 1);
    chk(sbq.size() == 0, "R8", "both devices sequenced", sbq.size(), 0);
    mon_on = 0;
  endtask

  initial begin
    run_seq(32'h0642, 32'h0385, 32'h0080, 32'h0000, 1'b0);
    run_seq(32'h0A53, 32'h0046, 32'h0000, 32'h0001, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule